// File: doc/BRIEF.md
# GPIB Listener Command Decoder

This block sits behind the byte-level handshake of an instrument-bus interface that drives a modular crate backplane. It follows the bus's interface messages, which are bytes flagged with ATN, and keeps track of the interface state: Idle, Listen, Talk or Serial-poll. It also raises the strobes that the backplane sequencer and the service-request logic need. The three-wire handshake is reduced to a one-cycle `byte_valid_i` strobe. IFC arrives as its own line.

While the block is a listener, the data bytes it receives (ATN low) are loaded into a command register file. Bits 7:6 of the first byte after the listen address choose what that byte is:

- a module command, which starts a function / subaddress / station / write-data sequence;
- a setup byte, which is held until Unlisten and then programs the transfer mode or the service-request enables;
- a global byte, which arms clear or initialise for the next backplane cycle and sets or drops inhibit.

When the talk address arrives outside Serial-poll, the block emits a one-cycle cycle request. The armed bits travel with that request.

Top module: `gpib_cmd_decoder`

## Requirements
- R1: After reset, or in the cycle after `ifc_i` is high, every output is zero and `state_o` is Idle (encoding: 0 Idle, 1 Listen, 2 Talk, 3 Serial-poll). This holds from any state.
- R2: Message 24 enters Serial-poll from any state. Message 25 in Serial-poll returns to Idle, clears `status_sel_o` and gives a one-cycle `srq_clr_o`. In any other state, message 25 is ignored.
- R3: Listen address (32 + `dev_addr_i`) enters Listen from Idle, Talk or Listen, and re-arms first-byte decoding; it is ignored in Serial-poll. Message 63 moves Listen to Idle.
- R4: Talk address (64 + `dev_addr_i`) outside Serial-poll enters Talk and pulses `cycle_req_o` for one cycle. Inside Serial-poll it sets `status_sel_o` and leaves the state unchanged. Message 95 moves Talk to Idle and clears `status_sel_o` in Serial-poll. With address 31, bytes 63 and 95 act as Unlisten and Untalk.
- R5: An ATN byte that matches no recognised message leaves every output unchanged. Data bytes received outside Listen are ignored.
- R6: Bits 7:6 of the first data byte after the listen address select the byte type: 00 is a module command with F = bits 4:0, 01 is setup, 10 is global, and 11 is ignored. After a first byte that is not a module command, further data bytes are ignored.
- R7: After a module byte, the following data bytes fill the fields in this order: subaddress (bits 3:0), station (bits 4:0), then `wdata_o` bits 7:0, 15:8 and 23:16. Any extra bytes are ignored. Fields that are not written keep their old value.
- R8: A setup byte with bit 5 set changes the transfer mode only at the next accepted Unlisten. `xfer_kind_o` takes bits 4:3 (00 single, 01 fast block, 11 slow block) and `xfer_width_o` takes bits 2:0 (001 8-bit, 010 16-bit, 100 24-bit). A kind of 10, or a width that is not one-hot, is ignored.
- R9: A setup byte with bit 5 clear takes effect at the next Unlisten. It loads `srq_en_o` from bits 2:0 (bit0 LAM, bit1 Q, bit2 X) and clears `inhibit_o`.
- R10: A global byte takes effect in the next cycle. Bit0 arms clear, bit1 arms initialise, bit2 sets inhibit and bit3 clears inhibit (bit3 wins). The arm bits stay high through the `cycle_req_o` pulse and drop in the cycle after it. Inhibit persists.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ifc_i | input | 1 | Interface clear, synchronous |
| dev_addr_i | input | 5 | Device address from switches |
| byte_valid_i | input | 1 | One-cycle byte strobe |
| atn_i | input | 1 | Byte is an interface message |
| byte_i | input | 8 | Bus byte |
| state_o | output | 2 | Interface state |
| cycle_req_o | output | 1 | Backplane cycle request pulse |
| status_sel_o | output | 1 | Serial-poll status output selected |
| srq_clr_o | output | 1 | Pending service request clear pulse |
| func_o | output | 5 | Function code |
| subaddr_o | output | 4 | Subaddress |
| station_o | output | 5 | Station number |
| wdata_o | output | 24 | Write data |
| arm_clear_o | output | 1 | Clear armed for next cycle |
| arm_init_o | output | 1 | Initialise armed for next cycle |
| inhibit_o | output | 1 | Inhibit level |
| xfer_kind_o | output | 2 | Transfer mode kind |
| xfer_width_o | output | 3 | Transfer width, one-hot |
| srq_en_o | output | 3 | Service-request enables |

## Verification
Every result is registered once: a byte sampled at a rising edge shows at the outputs straight after that edge. The cycle request and the service-request clear are high for exactly that one cycle, and the armed bits fall one edge later. The bench drives each byte on a falling edge, holds it for one cycle and compares all outputs at the next falling edge. At that point the pulses are still visible and the arms have not yet dropped. A setup byte is checked twice: once while it is still pending, where the outputs must be unchanged, and again after the Unlisten that commits it.

// File: rtl/cmd_dec_pkg.sv
package cmd_dec_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LISTEN = 2'd1,
    ST_TALK   = 2'd2,
    ST_SPOLL  = 2'd3
  } bus_state_e;

  localparam logic [7:0] MSG_SPE     = 8'd24;
  localparam logic [7:0] MSG_SPD     = 8'd25;
  localparam logic [7:0] MSG_UNL     = 8'd63;
  localparam logic [7:0] MSG_UNT     = 8'd95;
  localparam logic [7:0] BASE_LISTEN = 8'd32;
  localparam logic [7:0] BASE_TALK   = 8'd64;

  localparam logic [1:0] CLS_MODULE = 2'b00;
  localparam logic [1:0] CLS_SETUP  = 2'b01;
  localparam logic [1:0] CLS_GLOBAL = 2'b10;
endpackage

// File: rtl/bus_msg_fsm.sv
module bus_msg_fsm
  import cmd_dec_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ifc_i,
  input  logic              byte_valid_i,
  input  logic              atn_i,
  input  logic [7:0]        byte_i,
  input  logic [ADDR_W-1:0] dev_addr_i,
  output bus_state_e        state_o,
  output logic              cycle_req_o,
  output logic              status_sel_o,
  output logic              srq_clr_o,
  output logic              mla_o,
  output logic              unl_o
);
  bus_state_e st_q, st_d;
  logic sel_q, sel_d, req_q, req_d, clr_q, clr_d;
  logic msg, is_unl, is_unt, is_mla, is_mta;
  logic [7:0] my_listen, my_talk;

  assign my_listen = BASE_LISTEN + 8'(dev_addr_i);
  assign my_talk   = BASE_TALK + 8'(dev_addr_i);
  assign msg    = byte_valid_i & atn_i & ~ifc_i;
  assign is_unl = byte_i == MSG_UNL;
  assign is_unt = byte_i == MSG_UNT;
  assign is_mla = !is_unl && byte_i == my_listen;
  assign is_mta = !is_unt && byte_i == my_talk;
  assign mla_o  = msg & is_mla & (st_q != ST_SPOLL);
  assign unl_o  = msg & is_unl & (st_q == ST_LISTEN);

  always_comb begin
    st_d  = st_q;
    sel_d = sel_q;
    req_d = 1'b0;
    clr_d = 1'b0;
    if (msg) begin
      if (byte_i == MSG_SPE) st_d = ST_SPOLL;
      else if (byte_i == MSG_SPD) begin
        if (st_q == ST_SPOLL) begin
          st_d = ST_IDLE; sel_d = 1'b0; clr_d = 1'b1;
        end
      end else if (is_unl) begin
        if (st_q == ST_LISTEN) st_d = ST_IDLE;
      end else if (is_unt) begin
        if (st_q == ST_TALK) st_d = ST_IDLE;
        else if (st_q == ST_SPOLL) sel_d = 1'b0;
      end else if (is_mla) begin
        if (st_q != ST_SPOLL) st_d = ST_LISTEN;
      end else if (is_mta) begin
        if (st_q == ST_SPOLL) sel_d = 1'b1;
        else begin
          st_d = ST_TALK; req_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; sel_q <= 1'b0; req_q <= 1'b0; clr_q <= 1'b0;
    end else if (ifc_i) begin
      st_q <= ST_IDLE; sel_q <= 1'b0; req_q <= 1'b0; clr_q <= 1'b0;
    end else begin
      st_q <= st_d; sel_q <= sel_d; req_q <= req_d; clr_q <= clr_d;
    end
  end

  assign state_o      = st_q;
  assign cycle_req_o  = req_q;
  assign status_sel_o = sel_q;
  assign srq_clr_o    = clr_q;

  // R4
  req_in_talk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cycle_req_o |-> state_o == ST_TALK);
  // R4
  sel_in_spoll_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_sel_o |-> state_o == ST_SPOLL);
  // R1
  ifc_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(ifc_i) |-> state_o == ST_IDLE && !cycle_req_o && !status_sel_o);
  // R2
  srq_clr_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srq_clr_o |-> state_o == ST_IDLE && $past(state_o) == ST_SPOLL);
endmodule

// File: rtl/field_loader.sv
module field_loader
  import cmd_dec_pkg::*;
#(
  parameter int DATA_BYTES = 3,
  parameter int F_W = 5,
  parameter int A_W = 4,
  parameter int N_W = 5
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    ifc_i,
  input  logic                    dat_ok_i,
  input  logic                    mla_i,
  input  logic [7:0]              byte_i,
  output logic [F_W-1:0]          func_o,
  output logic [A_W-1:0]          subaddr_o,
  output logic [N_W-1:0]          station_o,
  output logic [8*DATA_BYTES-1:0] wdata_o,
  output logic                    setup_stb_o,
  output logic                    glob_stb_o
);
  localparam int IDX_DONE = DATA_BYTES + 3;
  localparam int IDX_W    = $clog2(IDX_DONE + 1);

  logic [IDX_W-1:0] idx_q;
  logic first;

  assign first       = dat_ok_i && idx_q == '0;
  assign setup_stb_o = first && byte_i[7:6] == CLS_SETUP;
  assign glob_stb_o  = first && byte_i[7:6] == CLS_GLOBAL;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) idx_q <= IDX_W'(IDX_DONE);
    else if (ifc_i) idx_q <= IDX_W'(IDX_DONE);
    else if (mla_i) idx_q <= '0;
    else if (first) idx_q <= (byte_i[7:6] == CLS_MODULE) ? IDX_W'(1) : IDX_W'(IDX_DONE);
    else if (dat_ok_i && idx_q < IDX_W'(IDX_DONE)) idx_q <= idx_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      func_o <= '0; subaddr_o <= '0; station_o <= '0;
    end else if (ifc_i) begin
      func_o <= '0; subaddr_o <= '0; station_o <= '0;
    end else if (dat_ok_i) begin
      if (idx_q == '0 && byte_i[7:6] == CLS_MODULE) func_o <= byte_i[F_W-1:0];
      if (idx_q == IDX_W'(1)) subaddr_o <= byte_i[A_W-1:0];
      if (idx_q == IDX_W'(2)) station_o <= byte_i[N_W-1:0];
    end
  end

  for (genvar g = 0; g < DATA_BYTES; g++) begin : g_lane
    logic [7:0] lane_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) lane_q <= '0;
      else if (ifc_i) lane_q <= '0;
      else if (dat_ok_i && idx_q == IDX_W'(3 + g)) lane_q <= byte_i;
    end
    assign wdata_o[8*g +: 8] = lane_q;
  end

  // R7
  func_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dat_ok_i && idx_q == '0) && !ifc_i |=> $stable(func_o));
  // R7
  sub_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dat_ok_i && idx_q == IDX_W'(1)) && !ifc_i |=> $stable(subaddr_o));
  // R6
  stb_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({setup_stb_o, glob_stb_o}));
endmodule

// File: rtl/ctl_regs.sv
module ctl_regs (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ifc_i,
  input  logic       setup_stb_i,
  input  logic       glob_stb_i,
  input  logic       unl_i,
  input  logic       cycle_req_i,
  input  logic [5:0] byte_i,
  output logic       arm_clear_o,
  output logic       arm_init_o,
  output logic       inhibit_o,
  output logic [1:0] xfer_kind_o,
  output logic [2:0] xfer_width_o,
  output logic [2:0] srq_en_o
);
  logic       pend_v_q;
  logic [5:0] pend_q;
  logic       mode_ok;

  assign mode_ok = $onehot(pend_q[2:0]) && pend_q[4:3] != 2'b10;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_v_q <= 1'b0; pend_q <= '0; arm_clear_o <= 1'b0; arm_init_o <= 1'b0;
      inhibit_o <= 1'b0; xfer_kind_o <= '0; xfer_width_o <= '0; srq_en_o <= '0;
    end else if (ifc_i) begin
      pend_v_q <= 1'b0; pend_q <= '0; arm_clear_o <= 1'b0; arm_init_o <= 1'b0;
      inhibit_o <= 1'b0; xfer_kind_o <= '0; xfer_width_o <= '0; srq_en_o <= '0;
    end else begin
      if (cycle_req_i) begin
        arm_clear_o <= 1'b0; arm_init_o <= 1'b0;
      end
      if (setup_stb_i) begin
        pend_v_q <= 1'b1; pend_q <= byte_i;
      end
      if (glob_stb_i) begin
        if (byte_i[0]) arm_clear_o <= 1'b1;
        if (byte_i[1]) arm_init_o <= 1'b1;
        if (byte_i[3]) inhibit_o <= 1'b0;
        else if (byte_i[2]) inhibit_o <= 1'b1;
      end
      if (unl_i && pend_v_q) begin
        pend_v_q <= 1'b0;
        if (!pend_q[5]) begin
          srq_en_o <= pend_q[2:0]; inhibit_o <= 1'b0;
        end else if (mode_ok) begin
          xfer_kind_o <= pend_q[4:3]; xfer_width_o <= pend_q[2:0];
        end
      end
    end
  end

  // R10
  inh_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(inhibit_o) |-> $past(glob_stb_i));
  // R10
  arm_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(arm_clear_o) |-> $past(cycle_req_i) || $past(ifc_i));
  // R8
  mode_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({xfer_kind_o, xfer_width_o}) |-> $past(unl_i) || $past(ifc_i));
  // R9
  srq_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(srq_en_o) |-> $past(unl_i) || $past(ifc_i));
endmodule

// File: rtl/gpib_cmd_decoder.sv
module gpib_cmd_decoder
  import cmd_dec_pkg::*;
#(
  parameter int ADDR_W     = 5,
  parameter int DATA_BYTES = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    ifc_i,
  input  logic [ADDR_W-1:0]       dev_addr_i,
  input  logic                    byte_valid_i,
  input  logic                    atn_i,
  input  logic [7:0]              byte_i,
  output logic [1:0]              state_o,
  output logic                    cycle_req_o,
  output logic                    status_sel_o,
  output logic                    srq_clr_o,
  output logic [4:0]              func_o,
  output logic [3:0]              subaddr_o,
  output logic [4:0]              station_o,
  output logic [8*DATA_BYTES-1:0] wdata_o,
  output logic                    arm_clear_o,
  output logic                    arm_init_o,
  output logic                    inhibit_o,
  output logic [1:0]              xfer_kind_o,
  output logic [2:0]              xfer_width_o,
  output logic [2:0]              srq_en_o
);
  bus_state_e st;
  logic mla, unl, dat_ok, setup_stb, glob_stb;

  assign state_o = st;
  assign dat_ok  = byte_valid_i & ~atn_i & ~ifc_i & (st == ST_LISTEN);

  bus_msg_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk_i, .rst_ni, .ifc_i, .byte_valid_i, .atn_i, .byte_i, .dev_addr_i,
    .state_o(st), .cycle_req_o, .status_sel_o, .srq_clr_o,
    .mla_o(mla), .unl_o(unl)
  );

  field_loader #(.DATA_BYTES(DATA_BYTES)) u_fields (
    .clk_i, .rst_ni, .ifc_i, .dat_ok_i(dat_ok), .mla_i(mla), .byte_i,
    .func_o, .subaddr_o, .station_o, .wdata_o,
    .setup_stb_o(setup_stb), .glob_stb_o(glob_stb)
  );

  ctl_regs u_ctl (
    .clk_i, .rst_ni, .ifc_i, .setup_stb_i(setup_stb), .glob_stb_i(glob_stb),
    .unl_i(unl), .cycle_req_i(cycle_req_o), .byte_i(byte_i[5:0]),
    .arm_clear_o, .arm_init_o, .inhibit_o, .xfer_kind_o, .xfer_width_o, .srq_en_o
  );
endmodule

// File: tb/gpib_cmd_decoder_tb.sv
module gpib_cmd_decoder_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, ifc = 1'b0, bv = 1'b0, atn = 1'b0;
  logic [4:0] addr = 5'd5;
  logic [7:0] bt = '0;
  logic [1:0] state; logic req, sel, sclr, armc, armz, inh;
  logic [4:0] fn, stn; logic [3:0] sub; logic [23:0] wd;
  logic [1:0] kind; logic [2:0] wid, srq;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // expected model state
  logic [1:0] e_st; logic e_req, e_sel, e_clr, e_c, e_z, e_inh, e_pv;
  logic [4:0] e_f, e_n; logic [3:0] e_a; logic [23:0] e_w;
  logic [1:0] e_kind; logic [2:0] e_wid, e_srq; logic [7:0] e_pb; int e_idx;

  always #5 clk = ~clk;

  gpib_cmd_decoder dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ifc_i(ifc), .dev_addr_i(addr), .byte_valid_i(bv),
    .atn_i(atn), .byte_i(bt), .state_o(state), .cycle_req_o(req), .status_sel_o(sel),
    .srq_clr_o(sclr), .func_o(fn), .subaddr_o(sub), .station_o(stn), .wdata_o(wd),
    .arm_clear_o(armc), .arm_init_o(armz), .inhibit_o(inh), .xfer_kind_o(kind),
    .xfer_width_o(wid), .srq_en_o(srq)
  );

  task automatic model_clear();
    e_st = 0; e_req = 0; e_sel = 0; e_clr = 0; e_c = 0; e_z = 0; e_inh = 0; e_pv = 0;
    e_f = 0; e_n = 0; e_a = 0; e_w = 0; e_kind = 0; e_wid = 0; e_srq = 0; e_pb = 0; e_idx = 6;
  endtask

  task automatic apply_pending();
    if (e_pv) begin
      e_pv = 0;
      if (!e_pb[5]) begin e_srq = e_pb[2:0]; e_inh = 0; end
      else if ((e_pb[2:0] == 1 || e_pb[2:0] == 2 || e_pb[2:0] == 4) && e_pb[4:3] != 2'b10) begin
        e_kind = e_pb[4:3]; e_wid = e_pb[2:0];
      end
    end
  endtask

  task automatic model(input logic a, input logic [7:0] b);
    logic [7:0] ml, mt;
    ml = 8'd32 + {3'b0, addr}; mt = 8'd64 + {3'b0, addr};
    if (e_req) begin e_c = 0; e_z = 0; end
    e_req = 0; e_clr = 0;
    if (a) begin
      if (b == 8'd24) e_st = 3;
      else if (b == 8'd25) begin if (e_st == 3) begin e_st = 0; e_sel = 0; e_clr = 1; end end
      else if (b == 8'd63) begin if (e_st == 1) begin e_st = 0; apply_pending(); end end
      else if (b == 8'd95) begin if (e_st == 2) e_st = 0; else if (e_st == 3) e_sel = 0; end
      else if (b == ml) begin if (e_st != 3) begin e_st = 1; e_idx = 0; end end
      else if (b == mt) begin if (e_st == 3) e_sel = 1; else begin e_st = 2; e_req = 1; end end
    end else if (e_st == 1) begin
      case (e_idx)
        0: begin
          e_idx = 6;
          if (b[7:6] == 2'b00) begin e_f = b[4:0]; e_idx = 1; end
          else if (b[7:6] == 2'b01) begin e_pv = 1; e_pb = b; end
          else if (b[7:6] == 2'b10) begin
            if (b[0]) e_c = 1;
            if (b[1]) e_z = 1;
            if (b[3]) e_inh = 0; else if (b[2]) e_inh = 1;
          end
        end
        1: begin e_a = b[3:0]; e_idx = 2; end
        2: begin e_n = b[4:0]; e_idx = 3; end
        3: begin e_w[7:0] = b; e_idx = 4; end
        4: begin e_w[15:8] = b; e_idx = 5; end
        5: begin e_w[23:16] = b; e_idx = 6; end
        default: ;
      endcase
    end
  endtask

  task automatic chk(input string tag, input string nm, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, nm, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk(tag, "state", 32'(state), 32'(e_st));
    chk(tag, "cycle_req", 32'(req), 32'(e_req));
    chk(tag, "status_sel", 32'(sel), 32'(e_sel));
    chk(tag, "srq_clr", 32'(sclr), 32'(e_clr));
    chk(tag, "fields", {3'b0, fn, sub, 15'b0, stn}, {3'b0, e_f, e_a, 15'b0, e_n});
    chk(tag, "wdata", 32'(wd), 32'(e_w));
    chk(tag, "arms_inh", {29'b0, armc, armz, inh}, {29'b0, e_c, e_z, e_inh});
    chk(tag, "mode", {24'b0, kind, wid, srq}, {24'b0, e_kind, e_wid, e_srq});
  endtask

  task automatic step(input logic a, input logic [7:0] b, input string tag);
    model(a, b);
    @(negedge clk); bv = 1; atn = a; bt = b;
    @(negedge clk); bv = 0; atn = 0;
    check_all(tag);
  endtask

  task automatic do_ifc(input string tag);
    model_clear();
    @(negedge clk); ifc = 1;
    @(negedge clk); ifc = 0;
    check_all(tag);
  endtask

  function automatic logic [7:0] pick_setup();
    int r = $urandom_range(0, 11);
    if (r < 9) return 8'd96 + 8'((r / 3 == 0) ? 0 : (r / 3 == 1) ? 8 : 24) + 8'(1 << (r % 3));
    if (r == 9) return 8'd64 + 8'($urandom_range(0, 7));
    return 8'd96 + 8'($urandom_range(0, 31));
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_all("R1 reset");

    // R3 / R6 / R7 full module command
    step(1, 8'd37, "R3 mla");
    step(0, 8'h0A, "R6 func");
    step(0, 8'hF7, "R7 sub");
    step(0, 8'd17, "R7 stn");
    step(0, 8'h11, "R7 w0"); step(0, 8'h22, "R7 w1"); step(0, 8'h33, "R7 w2");
    step(0, 8'h44, "R7 extra ignored");
    // R7 partial reload retains rest
    step(1, 8'd37, "R3 mla again");
    step(0, 8'h03, "R7 f only"); step(0, 8'h09, "R7 sub only");
    step(1, 8'd63, "R3 unl");
    // R5 data outside listen, unknown msg
    step(0, 8'h05, "R5 data idle");
    step(1, 8'h13, "R5 unknown atn");
    // R8 transfer mode pending until unlisten
    step(1, 8'd37, "R3"); step(0, 8'd106, "R8 pending"); step(0, 8'h01, "R6 after setup ignored");
    step(1, 8'd63, "R8 commit fast16");
    step(1, 8'd37, "R3"); step(0, 8'd121, "R8"); step(1, 8'd63, "R8 slow8");
    step(1, 8'd37, "R3"); step(0, 8'd99, "R8"); step(1, 8'd63, "R8 invalid width");
    step(1, 8'd37, "R3"); step(0, 8'd113, "R8"); step(1, 8'd63, "R8 invalid kind");
    // R10 global, R9 srq
    step(1, 8'd37, "R3"); step(0, 8'd135, "R10 arm+inh");
    step(1, 8'd37, "R3"); step(0, 8'd140, "R10 bit3 wins");
    step(0, 8'hC1, "R6 class3 ignored");
    step(1, 8'd37, "R3"); step(0, 8'd132, "R10 inh");
    step(1, 8'd37, "R3"); step(0, 8'd71, "R9 pending");
    step(1, 8'd63, "R9 commit");
    step(1, 8'd37, "R3"); step(0, 8'd131, "R10 arm");
    step(1, 8'd69, "R4 mta req");
    step(1, 8'd95, "R10 arms dropped");
    // R2 serial poll
    step(1, 8'd25, "R2 spd outside");
    step(1, 8'd24, "R2 spe");
    step(1, 8'd37, "R3 mla in spoll");
    step(1, 8'd69, "R4 mta in spoll");
    step(1, 8'd95, "R4 unt in spoll");
    step(1, 8'd69, "R4 mta in spoll");
    step(1, 8'd25, "R2 spd");
    // R4 address 31 collision
    addr = 5'd31;
    step(1, 8'd37, "R5 old addr");
    step(1, 8'd63, "R4 a31 unl");
    step(1, 8'd95, "R4 a31 unt");
    addr = 5'd5;
    step(1, 8'd37, "R3"); step(0, 8'h1F, "R7"); step(0, 8'h0F, "R7");
    do_ifc("R1 ifc");

    for (int i = 0; i < 2500; i++) begin
      int r = $urandom_range(0, 15);
      logic [7:0] ml = 8'd32 + {3'b0, addr};
      logic [7:0] mt = 8'd64 + {3'b0, addr};
      case (r)
        0, 1: step(1, ml, "R3 rnd");
        2:    step(1, 8'd63, "R3 rnd");
        3:    step(1, mt, "R4 rnd");
        4:    step(1, 8'd95, "R4 rnd");
        5:    step(1, 8'd24, "R2 rnd");
        6:    step(1, 8'd25, "R2 rnd");
        7:    step(1, 8'($urandom_range(0, 255)), "R5 rnd");
        8:    step(0, pick_setup(), "R8 rnd");
        9:    step(0, 8'd128 + 8'($urandom_range(0, 15)), "R10 rnd");
        10:   if ($urandom_range(0, 40) == 0) do_ifc("R1 rnd"); else step(0, 8'($urandom_range(0, 31)), "R6 rnd");
        default: step(0, 8'($urandom_range(0, 255)), "R7 rnd");
      endcase
      if (i == 1200) addr = 5'($urandom_range(0, 31));
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule